// File: doc/BRIEF.md
# Decimator Source Routing and Result Latch

This block sits between the analog array and a decimation filter. It picks a single comparator bit stream for the filter. The candidates are the four analog column comparators and a set of auxiliary sources. Along with the chosen stream, it forwards the 1x and 2x clocks of the matching analog column, so that data and timing always come from the same column. The clock column is given by the low bits of the source code, and this holds for the auxiliary codes too.

The block also decides when the filter's running accumulator is captured. In timer mode the decimation rate is zero, and the capture strobe is a one-cycle terminal-count pulse from one of four timers. Software picks the timer with a two-bit code whose bits come from two separate control registers. In internal mode the rate is nonzero, all timers are ignored, and a counter fires the capture on every N-th rising edge of the selected 1x column clock.

On each capture the accumulator is copied into a result buffer. The result is offered as a valid/ready stream, and `irq` pulses for one cycle. The buffer applies no back-pressure. A new capture overwrites the buffer whether or not the previous value was taken. An accepted handshake (`out_valid && out_ready`) clears the pending flag and leaves the data in place.

Top module: `dec_route_latch`

## Requirements
- R1: For `src_sel` 0 to 3, `dec_data` equals `cmp_col[src_sel]`. For `src_sel` 4 to 7, it equals `aux_src[src_sel-4]`. The path is combinational.
- R2: `dec_clk1x` and `dec_clk2x` equal `col_clk1x[src_sel[1:0]]` and `col_clk2x[src_sel[1:0]]` for every source code.
- R3: With `rate` = 0, the timer code is {`latch_sel_hi`,`latch_sel_lo`}. A high `timer_tc[code]` at a clock edge copies `acc_data` into `out_data` at that edge.
- R4: With `rate` = 0, pulses on timer inputs other than the selected one cause no capture, no `irq` and no change of `out_data`.
- R5: With `rate` = N > 0, all timer inputs are ignored. A capture happens on every N-th rising edge of the selected 1x clock, sampled by `clk`. Edges are counted from reset, from the last capture, or from the last cycle in which `rate` was 0.
- R6: `out_data` holds its value in every cycle without a capture.
- R7: In the cycle after a capture, `out_valid` is 1 and `irq` is 1. `irq` is high only in the cycle right after a capture.
- R8: A handshake with no capture in the same cycle clears `out_valid` in the next cycle and leaves `out_data` unchanged.
- R9: A capture in the same cycle as a handshake wins. `out_valid` stays 1 and `out_data` takes the new value.
- R10: While `rst_n` is low, `out_data` is 0, `out_valid` is 0, `irq` is 0, and the edge counter is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_col | input | 4 | Column comparator outputs |
| aux_src | input | 4 | Auxiliary data sources |
| col_clk1x | input | 4 | Per-column 1x clocks |
| col_clk2x | input | 4 | Per-column 2x clocks |
| src_sel | input | 3 | Data source code |
| latch_sel_lo | input | 1 | Timer code bit 0 |
| latch_sel_hi | input | 1 | Timer code bit 1 |
| timer_tc | input | 4 | Timer terminal-count pulses |
| rate | input | 8 | Decimation rate, 0 selects timer mode |
| acc_data | input | 16 | Accumulator value from the filter |
| out_ready | input | 1 | Consumer accepts the result |
| dec_data | output | 1 | Routed comparator bit |
| dec_clk1x | output | 1 | Routed 1x clock |
| dec_clk2x | output | 1 | Routed 2x clock |
| out_data | output | 16 | Result buffer |
| out_valid | output | 1 | Result pending flag |
| irq | output | 1 | One-cycle capture interrupt |

## Verification
The hardest case is internal-rate mode. There the capture depends on a count of column-clock edges, and that count is hidden. The only visible sign is which edge produces a result. The stimulus toggles one column clock by hand, with all timer inputs held high. It gives each edge a distinct accumulator value, so a capture on the wrong edge shows up as a mismatched value in the scoreboard. A capture that coincides with a handshake is forced by raising `out_ready` in the very cycle the selected timer pulses.

// File: rtl/dec_route_pkg.sv
package dec_route_pkg;
  typedef struct packed {
    logic data;
    logic clk1x;
    logic clk2x;
  } route_t;
endpackage

// File: rtl/dec_src_mux.sv
module dec_src_mux #(
  parameter int N_COL = 4,
  parameter int N_AUX = 4,
  localparam int N_SRC = N_COL + N_AUX,
  localparam int SEL_W = $clog2(N_SRC),
  localparam int COL_W = $clog2(N_COL)
) (
  input  logic [N_COL-1:0] cmp_col,
  input  logic [N_AUX-1:0] aux_src,
  input  logic [N_COL-1:0] col_clk1x,
  input  logic [N_COL-1:0] col_clk2x,
  input  logic [SEL_W-1:0] src_sel,
  output dec_route_pkg::route_t route
);
  logic [N_SRC-1:0] all_src;
  logic [COL_W-1:0] col_idx;

  generate
    for (genvar g = 0; g < N_SRC; g++) begin : g_src
      if (g < N_COL) begin : g_col
        assign all_src[g] = cmp_col[g];
      end else begin : g_aux
        assign all_src[g] = aux_src[g-N_COL];
      end
    end
  endgenerate

  assign col_idx = src_sel[COL_W-1:0];

  always_comb begin
    route.data  = all_src[src_sel];
    route.clk1x = col_clk1x[col_idx];
    route.clk2x = col_clk2x[col_idx];
  end
endmodule

// File: rtl/dec_latch_ctl.sv
module dec_latch_ctl #(
  parameter int N_TC   = 4,
  parameter int RATE_W = 8,
  localparam int TC_W  = $clog2(N_TC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TC_W-1:0]   tc_code,
  input  logic [N_TC-1:0]   timer_tc,
  input  logic [RATE_W-1:0] rate,
  input  logic              clk1x,
  output logic              latch_en
);
  logic              clk1x_q;
  logic              edge_1x;
  logic [RATE_W-1:0] edge_cnt;
  logic              internal_mode;
  logic              cnt_wrap;

  assign internal_mode = (rate != '0);
  assign edge_1x       = clk1x & ~clk1x_q;
  assign cnt_wrap      = edge_1x && (edge_cnt >= rate - RATE_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk1x_q  <= 1'b1;
      edge_cnt <= '0;
    end else begin
      clk1x_q <= clk1x;
      if (!internal_mode)
        edge_cnt <= '0;
      else if (cnt_wrap)
        edge_cnt <= '0;
      else if (edge_1x)
        edge_cnt <= edge_cnt + RATE_W'(1);
    end
  end

  always_comb begin
    if (internal_mode)
      latch_en = cnt_wrap;
    else
      latch_en = timer_tc[tc_code];
  end
endmodule

// File: rtl/dec_out_buf.sv
module dec_out_buf #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             latch_en,
  input  logic [ACC_W-1:0] acc_data,
  input  logic             out_ready,
  output logic [ACC_W-1:0] out_data,
  output logic             out_valid,
  output logic             irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_data  <= '0;
      out_valid <= 1'b0;
      irq       <= 1'b0;
    end else begin
      irq <= latch_en;
      if (latch_en) begin
        out_data  <= acc_data;
        out_valid <= 1'b1;
      end else if (out_valid && out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dec_route_latch.sv
module dec_route_latch #(
  parameter int N_COL  = 4,
  parameter int N_AUX  = 4,
  parameter int RATE_W = 8,
  parameter int ACC_W  = 16,
  localparam int N_TC  = 4,
  localparam int SEL_W = $clog2(N_COL + N_AUX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_COL-1:0]  cmp_col,
  input  logic [N_AUX-1:0]  aux_src,
  input  logic [N_COL-1:0]  col_clk1x,
  input  logic [N_COL-1:0]  col_clk2x,
  input  logic [SEL_W-1:0]  src_sel,
  input  logic              latch_sel_lo,
  input  logic              latch_sel_hi,
  input  logic [N_TC-1:0]   timer_tc,
  input  logic [RATE_W-1:0] rate,
  input  logic [ACC_W-1:0]  acc_data,
  input  logic              out_ready,
  output logic              dec_data,
  output logic              dec_clk1x,
  output logic              dec_clk2x,
  output logic [ACC_W-1:0]  out_data,
  output logic              out_valid,
  output logic              irq
);
  dec_route_pkg::route_t route;
  logic                  latch_en;

  dec_src_mux #(.N_COL(N_COL), .N_AUX(N_AUX)) u_mux (
    .cmp_col(cmp_col), .aux_src(aux_src), .col_clk1x(col_clk1x),
    .col_clk2x(col_clk2x), .src_sel(src_sel), .route(route)
  );

  assign dec_data  = route.data;
  assign dec_clk1x = route.clk1x;
  assign dec_clk2x = route.clk2x;

  dec_latch_ctl #(.N_TC(N_TC), .RATE_W(RATE_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .tc_code({latch_sel_hi, latch_sel_lo}),
    .timer_tc(timer_tc), .rate(rate), .clk1x(route.clk1x), .latch_en(latch_en)
  );

  dec_out_buf #(.ACC_W(ACC_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .latch_en(latch_en), .acc_data(acc_data),
    .out_ready(out_ready), .out_data(out_data), .out_valid(out_valid), .irq(irq)
  );
endmodule

// File: rtl/dec_route_latch_chk.sv
module dec_route_latch_chk #(
  parameter int RATE_W = 8,
  parameter int ACC_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              latch_en,
  input logic [3:0]        timer_tc,
  input logic [RATE_W-1:0] rate,
  input logic              dec_clk1x,
  input logic              out_ready,
  input logic [ACC_W-1:0]  out_data,
  input logic              out_valid,
  input logic              irq
);
  AST_HOLD_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n) !latch_en |=> $stable(out_data)); // R6
  AST_LATCH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) latch_en |=> (out_valid && irq)); // R7
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) irq |-> $past(latch_en)); // R7
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_ready && !latch_en) |=> !out_valid); // R8
  AST_IDLE_TIMERS: assert property (@(posedge clk) disable iff (!rst_n) (rate == '0 && timer_tc == 4'b0) |-> !latch_en); // R4
  AST_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n) (rate != '0 && !(dec_clk1x && !$past(dec_clk1x))) |-> !latch_en); // R5
endmodule

bind dec_route_latch dec_route_latch_chk #(.RATE_W(RATE_W), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .latch_en(latch_en), .timer_tc(timer_tc),
  .rate(rate), .dec_clk1x(dec_clk1x), .out_ready(out_ready),
  .out_data(out_data), .out_valid(out_valid), .irq(irq)
);

// File: tb/dec_route_latch_test.sv
`timescale 1ns/1ps
module dec_route_latch_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] cmp_col = '0, aux_src = '0, col_clk1x = '0, col_clk2x = '0;
  logic [2:0] src_sel = '0;
  logic latch_sel_lo = 1'b0, latch_sel_hi = 1'b0;
  logic [3:0] timer_tc = '0;
  logic [7:0] rate = '0;
  logic [15:0] acc_data = '0;
  logic out_ready = 1'b0;
  logic dec_data, dec_clk1x, dec_clk2x, out_valid, irq;
  logic [15:0] out_data;

  int checks = 0;
  int fails = 0;
  logic [15:0] expq[$];

  always #2.5 clk = ~clk;

  dec_route_latch uut (
    .clk(clk), .rst_n(rst_n), .cmp_col(cmp_col), .aux_src(aux_src),
    .col_clk1x(col_clk1x), .col_clk2x(col_clk2x), .src_sel(src_sel),
    .latch_sel_lo(latch_sel_lo), .latch_sel_hi(latch_sel_hi),
    .timer_tc(timer_tc), .rate(rate), .acc_data(acc_data),
    .out_ready(out_ready), .dec_data(dec_data), .dec_clk1x(dec_clk1x),
    .dec_clk2x(dec_clk2x), .out_data(out_data), .out_valid(out_valid), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: every irq must match one queued capture (R3/R5/R7)
  always @(negedge clk) begin
    if (rst_n && irq) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R4/R5 unexpected capture", {16'h0, out_data}, 32'h0);
      end else begin
        logic [15:0] e;
        e = expq.pop_front();
        chk(out_data == e && out_valid, "R3/R5/R7 captured value", {16'h0, out_data}, {16'h0, e});
      end
    end
  end

  task automatic timer_latch(input int code, input logic [15:0] val, input bit rdy);
    @(negedge clk);
    {latch_sel_hi, latch_sel_lo} = 2'(code);
    timer_tc = 4'b1 << code;
    acc_data = val;
    out_ready = rdy;
    expq.push_back(val);
    @(negedge clk);
    timer_tc = '0;
    out_ready = 1'b0;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(out_valid == 1'b0, "R10 valid in reset", 32'(out_valid), 0);
    chk(irq == 1'b0, "R10 irq in reset", 32'(irq), 0);
    chk(out_data == 16'h0, "R10 data in reset", 32'(out_data), 0);
    rst_n = 1'b1;

    // R1 / R2 routing
    for (int s = 0; s < 8; s++) begin
      cmp_col = 4'b0110; aux_src = 4'b1001;
      col_clk1x = 4'b1 << (s % 4); col_clk2x = ~(4'b1 << (s % 4));
      src_sel = 3'(s);
      #1;
      chk(dec_data == (s < 4 ? cmp_col[s%4] : aux_src[s%4]), "R1 data route", 32'(dec_data), 32'(s < 4 ? cmp_col[s%4] : aux_src[s%4]));
      chk(dec_clk1x == 1'b1, "R2 1x clock route", 32'(dec_clk1x), 1);
      chk(dec_clk2x == 1'b0, "R2 2x clock route", 32'(dec_clk2x), 0);
      cmp_col = ~cmp_col; aux_src = ~aux_src;
      #1;
      chk(dec_data == (s < 4 ? cmp_col[s%4] : aux_src[s%4]), "R1 data route inverted", 32'(dec_data), 32'(s < 4 ? cmp_col[s%4] : aux_src[s%4]));
    end
    col_clk1x = '0; col_clk2x = '0; src_sel = '0;

    // R3 every timer code
    for (int c = 0; c < 4; c++) timer_latch(c, 16'h1100 + 16'(c), 1'b0);
    chk(out_valid == 1'b1, "R7 valid after capture", 32'(out_valid), 1);

    // R4 / R6 unselected timers ignored (code 2 selected)
    @(negedge clk);
    {latch_sel_hi, latch_sel_lo} = 2'd2; timer_tc = 4'b1011; acc_data = 16'hDEAD;
    @(negedge clk);
    timer_tc = '0;
    chk(irq == 1'b0, "R4 no irq from other timers", 32'(irq), 0);
    chk(out_data == 16'h1103, "R4/R6 data held", 32'(out_data), 32'h1103);

    // R8 handshake clears flag, keeps data
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(out_valid == 1'b0, "R8 valid cleared", 32'(out_valid), 0);
    chk(out_data == 16'h1103, "R8 data kept", 32'(out_data), 32'h1103);

    // R9 capture with simultaneous handshake
    timer_latch(1, 16'h2222, 1'b0);
    timer_latch(1, 16'h3333, 1'b1);
    chk(out_valid == 1'b1, "R9 valid kept", 32'(out_valid), 1);
    chk(out_data == 16'h3333, "R9 new data", 32'(out_data), 32'h3333);

    // R5 internal rate 3 on column 1, timers held high and ignored
    @(negedge clk);
    src_sel = 3'd1; rate = 8'd3; timer_tc = 4'hF;
    @(negedge clk);
    for (int r = 1; r <= 6; r++) begin
      col_clk1x[1] = 1'b1; acc_data = 16'h4000 + 16'(r);
      if (r % 3 == 0) expq.push_back(16'h4000 + 16'(r));
      @(negedge clk); col_clk1x[1] = 1'b0;
      @(negedge clk);
      @(negedge clk);
    end
    chk(out_data == 16'h4006, "R5 rate 3 last capture", 32'(out_data), 32'h4006);

    // R5 rate 1 via auxiliary code 5 (clock column 1)
    src_sel = 3'd5; rate = 8'd1;
    @(negedge clk);
    for (int r = 0; r < 3; r++) begin
      col_clk1x[1] = 1'b1; acc_data = 16'h5000 + 16'(r);
      expq.push_back(16'h5000 + 16'(r));
      @(negedge clk); col_clk1x[1] = 1'b0;
      @(negedge clk);
    end
    timer_tc = '0; rate = '0;
    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "R5 all expected captures seen", 32'(expq.size()), 0);
    chk(out_data == 16'h5002, "R6 final data held", 32'(out_data), 32'h5002);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule